// File: doc/BRIEF.md
# Bubble-Free Pipelined Synchronous SRAM

This block is an on-chip synchronous static memory arranged as a two-stage pipeline. Address and control are sampled on one clock edge, and the data for that command moves two edges later, whether the command is a read or a write. Because both directions share the same latency, a write may follow a read, and a read may follow a write, in consecutive cycles with no idle bus cycle between them. The data bus is split into an input port, an output port and an output-enable, which a pad ring or an on-chip bus can merge as needed.

Each command can carry a new address, or it can ask the block to advance an internal four-step burst counter. The counter runs in one of two orders, chosen when the burst starts. Three chip enables gate the start of a new command. A byte-lane mask selects the lanes that a write stores. A clock enable freezes the entire pipeline. An asynchronous output enable can turn off the output drive at any moment.

Top module: `bubbleless_sram`

## Requirements
- R1: A write command sampled at edge k stores the value present on `d_in` at edge k+2 into the addressed word.
- R2: A read command sampled at edge k puts the addressed word on `d_out` with `d_oe` high from edge k+1 until edge k+2, if `out_en` is high.
- R3: Reads and writes can alternate in consecutive cycles. A read issued one cycle after a write to the same word returns the newly written lanes, and the same holds for a read issued two cycles after the write.
- R4: A command with `adv` low and any chip enable inactive (`sel_a` low, `sel_b` low or `sel_n_c` high) starts nothing: no lane is written and `d_oe` stays low for that slot.
- R5: A command already accepted still completes when the cycles after it are deselected.
- R6: `d_oe` is low in the data slot of any write, deselect or idle command. In practice the bus is released one edge after such a command is sampled.
- R7: Lane i of the word is bits [9i+8:9i]. A write stores only the lanes whose `lane_we` bit was 1 when the command was sampled. A mask of 0 leaves the word unchanged.
- R8: While `clk_en` is low, every pipeline register holds its value. No write is stored, no command is accepted, and `d_out` and `d_oe` do not change.
- R9: `out_en` low forces `d_oe` low at once, without waiting for a clock, and has no effect on the pipeline.
- R10: With `adv` high, the block repeats the operation type of the last load and steps a two-bit offset c = 1, 2, 3, 0. The low two address bits become base+c (mod 4) when `burst_lin` was 1 at the load, or base XOR c when it was 0. The upper address bits keep the value from the load.
- R11: When the last load was deselected, a command with `adv` high stays idle.
- R12: While `rst_n` is low at an edge, the pipeline clears, so `d_oe` is low afterwards and no pending command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | 1 = pipeline advances, 0 = everything holds |
| adv | input | 1 | 0 = load new address and command, 1 = continue burst |
| wr | input | 1 | 1 = write, 0 = read (used on load) |
| sel_a | input | 1 | Chip enable, active high |
| sel_b | input | 1 | Chip enable, active high |
| sel_n_c | input | 1 | Chip enable, active low |
| burst_lin | input | 1 | Burst order on load: 1 = add, 0 = XOR |
| addr | input | ADDR_W (8) | Word address on load |
| lane_we | input | LANES (4) | Write lane mask for this command |
| d_in | input | LANES*LANE_W (36) | Write data, sampled two edges after the command |
| out_en | input | 1 | Asynchronous output enable |
| d_out | output | LANES*LANE_W (36) | Read data |
| d_oe | output | 1 | Read data is being driven |

## Verification
Each command slot appears at the ports exactly one or two edges after it is sampled. A stuck or misrouted stage-one register therefore shows up as a wrong `d_oe` or a wrong `d_out` one edge after the command. A stage-two or burst fault shows up only when a later read returns the word that should have been written, which is why every write sequence in the bench ends with read-backs. Suspend faults show up as output changes while `clk_en` is low, or as the wrong `d_in` sample being stored. Bypass faults appear on the read placed directly behind a write to the same word.

// File: rtl/bls_pkg.sv
// Shared encodings for the bubble-free SRAM.
// Assumes: a single command type bit and a single burst order bit.
package bls_pkg;
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef enum logic {
        ORD_XOR = 1'b0,
        ORD_ADD = 1'b1
    } order_e;
endpackage

// File: rtl/bls_cmd_seq.sv
// Command front end: decodes the chip enables, loads or advances the burst
// state and registers the resulting command into pipeline stage one.
// Assumes: ADDR_W > BURST_W; burst offsets wrap within 2**BURST_W words.
module bls_cmd_seq
    import bls_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv,
    input  logic              wr,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_n_c,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    output logic              s1_valid,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_mask
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic               chips_on;
    logic [BURST_W-1:0] cnt_next;
    logic [BURST_W-1:0] burst_low;
    logic               nx_valid;
    op_e                nx_op;
    logic [ADDR_W-1:0]  nx_addr;

    logic               s1_valid_q;
    op_e                s1_op_q;
    logic [ADDR_W-1:0]  s1_addr_q;
    logic [LANES-1:0]   s1_mask_q;

    logic               bst_act_q;
    op_e                bst_op_q;
    logic [HI_W-1:0]    bst_hi_q;
    logic [BURST_W-1:0] bst_base_q;
    logic [BURST_W-1:0] bst_cnt_q;
    order_e             bst_ord_q;

    // All three enables must agree before a load may start an operation.
    assign chips_on = sel_a & sel_b & ~sel_n_c;

    // Next burst offset and the low address bits it produces in either order.
    always_comb begin
        cnt_next  = bst_cnt_q + {{(BURST_W-1){1'b0}}, 1'b1};
        burst_low = (bst_ord_q == ORD_ADD) ? (bst_base_q + cnt_next)
                                           : (bst_base_q ^ cnt_next);
    end

    // Choose between a freshly loaded command and a burst continuation.
    always_comb begin
        if (!adv) begin
            nx_valid = chips_on;
            nx_op    = op_e'(wr);
            nx_addr  = addr;
        end else begin
            nx_valid = bst_act_q;
            nx_op    = bst_op_q;
            nx_addr  = {bst_hi_q, burst_low};
        end
    end

    // Stage-one command register, frozen while the clock enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_op_q    <= OP_READ;
            s1_addr_q  <= '0;
            s1_mask_q  <= '0;
        end else if (clk_en) begin
            s1_valid_q <= nx_valid;
            s1_op_q    <= nx_op;
            s1_addr_q  <= nx_addr;
            s1_mask_q  <= lane_we;
        end
    end

    // Burst state: captured on every load, counter stepped on every advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_act_q  <= 1'b0;
            bst_op_q   <= OP_READ;
            bst_hi_q   <= '0;
            bst_base_q <= '0;
            bst_cnt_q  <= '0;
            bst_ord_q  <= ORD_XOR;
        end else if (clk_en) begin
            if (!adv) begin
                bst_act_q  <= chips_on;
                bst_op_q   <= op_e'(wr);
                bst_hi_q   <= addr[ADDR_W-1:BURST_W];
                bst_base_q <= addr[BURST_W-1:0];
                bst_cnt_q  <= '0;
                bst_ord_q  <= order_e'(burst_lin);
            end else begin
                bst_cnt_q  <= cnt_next;
            end
        end
    end

    assign s1_valid = s1_valid_q;
    assign s1_op    = s1_op_q;
    assign s1_addr  = s1_addr_q;
    assign s1_mask  = s1_mask_q;

    // R4
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && !(sel_a && sel_b && !sel_n_c)) |=> !s1_valid_q);

    // R10
    burst_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && bst_act_q) |=>
            (s1_valid_q && s1_addr_q[BURST_W-1:0] != $past(s1_addr_q[BURST_W-1:0])));

    // R11
    burst_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && !bst_act_q) |=> !s1_valid_q);
endmodule

// File: rtl/bls_lane_array.sv
// Storage split into byte lanes. Each lane is written with its own mask bit
// and read into an output register. A read that coincides with a write to
// the same word takes the written lanes from the write data (same-edge bypass).
// Assumes: storage is not reset; one read and one write port per edge.
module bls_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    clk_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;

    // Flags a read and a write to one word at the same edge.
    assign same_word = wr_en && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane write, gated by the lane's mask bit and the clock enable.
        always_ff @(posedge clk) begin
            if (clk_en && wr_en && wr_mask[g]) begin
                mem_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Lane read register, with bypass of a coinciding write.
        always_ff @(posedge clk) begin
            if (clk_en && rd_en) begin
                if (same_word && wr_mask[g]) begin
                    rd_q <= wr_data[g*LANE_W +: LANE_W];
                end else begin
                    rd_q <= mem_q[rd_addr];
                end
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/bubbleless_sram.sv
// Top of the bubble-free pipelined SRAM. Stage one (bls_cmd_seq) holds the
// sampled command. The array is read as that command enters stage two, and a
// write is stored as it leaves stage two, together with d_in. Read and write
// data therefore both sit two edges after their command.
// Assumes: d_in is valid at the edge two edges after a write command.
module bubbleless_sram
    import bls_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    adv,
    input  logic                    wr,
    input  logic                    sel_a,
    input  logic                    sel_b,
    input  logic                    sel_n_c,
    input  logic                    burst_lin,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] d_in,
    input  logic                    out_en,
    output logic [LANES*LANE_W-1:0] d_out,
    output logic                    d_oe
);
    logic              s1_valid;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;

    logic              s2_valid_q;
    op_e               s2_op_q;
    logic [ADDR_W-1:0] s2_addr_q;
    logic [LANES-1:0]  s2_mask_q;
    logic              drive_q;

    logic              arr_wr_en;
    logic              arr_rd_en;

    bls_cmd_seq #(
        .ADDR_W  (ADDR_W),
        .LANES   (LANES),
        .BURST_W (BURST_W)
    ) i_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv       (adv),
        .wr        (wr),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_n_c   (sel_n_c),
        .burst_lin (burst_lin),
        .addr      (addr),
        .lane_we   (lane_we),
        .s1_valid  (s1_valid),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_mask   (s1_mask)
    );

    // Stage-two register: carries the command to its data edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid_q <= 1'b0;
            s2_op_q    <= OP_READ;
            s2_addr_q  <= '0;
            s2_mask_q  <= '0;
        end else if (clk_en) begin
            s2_valid_q <= s1_valid;
            s2_op_q    <= s1_op;
            s2_addr_q  <= s1_addr;
            s2_mask_q  <= s1_mask;
        end
    end

    // Output drive flag: set for the data slot of a read, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else if (clk_en) begin
            drive_q <= s1_valid && (s1_op == OP_READ);
        end
    end

    // Port strobes: write leaves stage two, read enters it.
    assign arr_wr_en = s2_valid_q && (s2_op_q == OP_WRITE);
    assign arr_rd_en = s1_valid && (s1_op == OP_READ);

    bls_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_lane_array (
        .clk     (clk),
        .clk_en  (clk_en),
        .wr_en   (arr_wr_en),
        .wr_addr (s2_addr_q),
        .wr_mask (s2_mask_q),
        .wr_data (d_in),
        .rd_en   (arr_rd_en),
        .rd_addr (s1_addr),
        .rd_data (d_out)
    );

    // Asynchronous output enable gates the registered drive flag.
    assign d_oe = out_en & drive_q;

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s1_valid && s1_op == OP_READ) |=> drive_q);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !(s1_valid && s1_op == OP_READ)) |=> !drive_q);

    // R5
    pending_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s1_valid) |=> s2_valid_q);

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(s2_valid_q) && $stable(drive_q) && $stable(d_out)));
endmodule

// File: tb/test_bubbleless_sram.sv
module test_bubbleless_sram;
    localparam int DW = 36;
    localparam logic [2:0]    CSON = 3'b110;
    localparam logic [DW-1:0] JUNK = 36'hB_ADBA_DBAD;

    typedef struct packed {
        logic          adv;
        logic          wr;
        logic [2:0]    cs;    // {sel_a, sel_b, sel_n_c}
        logic          lin;
        logic          act;   // bench: command really starts
        logic [7:0]    addr;
        logic [7:0]    eff;   // bench: word the command touches
        logic [3:0]    mask;
        logic [DW-1:0] data;
        logic [3:0]    req;
    } op_t;

    // Main vectors: R1 writes, R3 read right after write (bypass), R7 lane masks, R5 deselect.
    localparam op_t MAIN_T [12] = '{
        '{1'b0,1'b1,CSON,  1'b1,1'b1,8'h10,8'h10,4'hF,36'h1_2345_6789,4'd1},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h10,8'h10,4'hF,36'h0,          4'd3},
        '{1'b0,1'b1,CSON,  1'b1,1'b1,8'h11,8'h11,4'hF,36'hA_BCDE_F012,4'd1},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h10,8'h10,4'hF,36'h0,          4'd2},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h11,8'h11,4'hF,36'h0,          4'd3},
        '{1'b0,1'b1,CSON,  1'b1,1'b1,8'h10,8'h10,4'h5,36'hF_FFFF_FFFF,4'd7},
        '{1'b0,1'b0,3'b010,1'b1,1'b0,8'h10,8'h10,4'hF,36'h0,          4'd5},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h10,8'h10,4'hF,36'h0,          4'd7},
        '{1'b0,1'b1,CSON,  1'b1,1'b1,8'h11,8'h11,4'h0,36'h0,          4'd7},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h11,8'h11,4'hF,36'h0,          4'd7},
        '{1'b0,1'b1,CSON,  1'b1,1'b1,8'h20,8'h20,4'hF,36'h0_0000_0001,4'd1},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h20,8'h20,4'hF,36'h0,          4'd2}
    };

    // Burst vectors: R10 add order then XOR order, R4 each enable off, R11 advance after deselect.
    localparam op_t BURST_T [15] = '{
        '{1'b0,1'b1,CSON,  1'b1,1'b1,8'h41,8'h41,4'hF,36'h1_1111_1111,4'd10},
        '{1'b1,1'b1,CSON,  1'b1,1'b1,8'h00,8'h42,4'hF,36'h2_2222_2222,4'd10},
        '{1'b1,1'b1,CSON,  1'b1,1'b1,8'h00,8'h43,4'hF,36'h3_3333_3333,4'd10},
        '{1'b1,1'b1,CSON,  1'b1,1'b1,8'h00,8'h40,4'hF,36'h4_4444_4444,4'd10},
        '{1'b0,1'b0,CSON,  1'b0,1'b1,8'h42,8'h42,4'hF,36'h0,          4'd10},
        '{1'b1,1'b0,CSON,  1'b0,1'b1,8'h00,8'h43,4'hF,36'h0,          4'd10},
        '{1'b1,1'b0,CSON,  1'b0,1'b1,8'h00,8'h40,4'hF,36'h0,          4'd10},
        '{1'b1,1'b0,CSON,  1'b0,1'b1,8'h00,8'h41,4'hF,36'h0,          4'd10},
        '{1'b0,1'b1,3'b111,1'b1,1'b0,8'h40,8'h40,4'hF,36'h0,          4'd4},
        '{1'b1,1'b1,CSON,  1'b1,1'b0,8'h00,8'h41,4'hF,36'h0,          4'd11},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h40,8'h40,4'hF,36'h0,          4'd11},
        '{1'b0,1'b1,3'b100,1'b1,1'b0,8'h41,8'h41,4'hF,36'h0,          4'd4},
        '{1'b0,1'b1,3'b010,1'b1,1'b0,8'h42,8'h42,4'hF,36'h0,          4'd4},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h41,8'h41,4'hF,36'h0,          4'd4},
        '{1'b0,1'b0,CSON,  1'b1,1'b1,8'h42,8'h42,4'hF,36'h0,          4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          adv = 1'b0;
    logic          wr = 1'b0;
    logic          sel_a = 1'b0;
    logic          sel_b = 1'b0;
    logic          sel_n_c = 1'b1;
    logic          burst_lin = 1'b1;
    logic [7:0]    addr = '0;
    logic [3:0]    lane_we = '0;
    logic [DW-1:0] d_in = '0;
    logic          out_en = 1'b1;
    logic [DW-1:0] d_out;
    logic          d_oe;

    int            n_run = 0;
    int            n_fail = 0;
    logic [DW-1:0] ref_mem [256];
    op_t           prog [16];

    always #2 clk = ~clk;

    bubbleless_sram i_bubbleless_sram (
        .clk (clk), .rst_n (rst_n), .clk_en (clk_en), .adv (adv), .wr (wr),
        .sel_a (sel_a), .sel_b (sel_b), .sel_n_c (sel_n_c),
        .burst_lin (burst_lin), .addr (addr), .lane_we (lane_we),
        .d_in (d_in), .out_en (out_en), .d_out (d_out), .d_oe (d_oe)
    );

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
        end
    endtask

    task automatic drive_op(input op_t op);
        adv = op.adv; wr = op.wr; {sel_a, sel_b, sel_n_c} = op.cs;
        burst_lin = op.lin; addr = op.addr; lane_we = op.mask;
    endtask

    task automatic drive_idle();
        adv = 1'b0; wr = 1'b0; {sel_a, sel_b, sel_n_c} = 3'b001; lane_we = '0;
    endtask

    // Reference write following R7 lane layout: lane i = bits [9i+8:9i].
    task automatic ref_write(input logic [7:0] a, input logic [3:0] m, input logic [DW-1:0] v);
        for (int l = 0; l < 4; l++) begin
            if (m[l]) ref_mem[a][l*9 +: 9] = v[l*9 +: 9];
        end
    endtask

    // Issues prog[0..n-1] one per cycle; write data two edges later (R1),
    // read result checked between edge k+1 and k+2 (R2), released slots (R6).
    task automatic run_prog(input int n);
        for (int i = 0; i < n + 2; i++) begin
            if (i < n) drive_op(prog[i]); else drive_idle();
            d_in = JUNK;
            if (i >= 2) begin
                if (prog[i-2].act && prog[i-2].wr) d_in = prog[i-2].data;
            end
            @(negedge clk);
            if (i >= 2) begin
                if (prog[i-2].act && prog[i-2].wr)
                    ref_write(prog[i-2].eff, prog[i-2].mask, prog[i-2].data);
            end
            if (i >= 1 && i <= n) begin
                if (prog[i-1].act && !prog[i-1].wr) begin
                    check(d_oe === 1'b1 && d_out === ref_mem[prog[i-1].eff],
                          $sformatf("R%0d read slot %0d", prog[i-1].req, i-1),
                          d_out, ref_mem[prog[i-1].eff]);
                end else begin
                    // R6 bus released for write/deselect slots
                    check(d_oe === 1'b0, $sformatf("R6 slot %0d (R%0d)", i-1, prog[i-1].req),
                          {35'b0, d_oe}, '0);
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 256; a++) ref_mem[a] = '0;
        drive_idle();
        // R12 reset state
        repeat (3) @(negedge clk);
        check(d_oe === 1'b0, "R12 reset", {35'b0, d_oe}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 12; i++) prog[i] = MAIN_T[i];
        run_prog(12);
        for (int i = 0; i < 15; i++) prog[i] = BURST_T[i];
        run_prog(15);

        // Setup for R8: known words at 0x30 and 0x31.
        prog[0] = '{1'b0,1'b1,CSON,1'b1,1'b1,8'h30,8'h30,4'hF,36'h7_0000_0030,4'd1};
        prog[1] = '{1'b0,1'b1,CSON,1'b1,1'b1,8'h31,8'h31,4'hF,36'h7_0000_0031,4'd1};
        run_prog(2);

        // R8 suspend while a write is pending and new commands are offered.
        drive_op('{1'b0,1'b1,CSON,1'b1,1'b1,8'h30,8'h30,4'hF,36'h0,4'd8});
        d_in = JUNK;
        @(negedge clk);
        clk_en = 1'b0;
        drive_op('{1'b0,1'b1,CSON,1'b1,1'b1,8'h31,8'h31,4'hF,36'h0,4'd8});
        repeat (3) @(negedge clk);
        check(d_oe === 1'b0, "R8 no drive during suspend", {35'b0, d_oe}, '0);
        clk_en = 1'b1;
        drive_idle();
        @(negedge clk);
        d_in = 36'h5_A5A5_A5A5;
        @(negedge clk);
        d_in = JUNK;
        ref_write(8'h30, 4'hF, 36'h5_A5A5_A5A5);
        prog[0] = '{1'b0,1'b0,CSON,1'b1,1'b1,8'h30,8'h30,4'hF,36'h0,4'd8};
        prog[1] = '{1'b0,1'b0,CSON,1'b1,1'b1,8'h31,8'h31,4'hF,36'h0,4'd8};
        run_prog(2);

        // R8 read output holds through a suspend.
        drive_op('{1'b0,1'b0,CSON,1'b1,1'b1,8'h30,8'h30,4'hF,36'h0,4'd8});
        @(negedge clk);
        drive_idle();
        @(negedge clk);
        check(d_oe === 1'b1 && d_out === ref_mem[8'h30], "R2 read before suspend", d_out, ref_mem[8'h30]);
        clk_en = 1'b0;
        repeat (2) @(negedge clk);
        check(d_oe === 1'b1 && d_out === ref_mem[8'h30], "R8 read held", d_out, ref_mem[8'h30]);
        clk_en = 1'b1;
        @(negedge clk);
        check(d_oe === 1'b0, "R6 released after suspend", {35'b0, d_oe}, '0);

        // R9 asynchronous output enable.
        out_en = 1'b0;
        drive_op('{1'b0,1'b0,CSON,1'b1,1'b1,8'h31,8'h31,4'hF,36'h0,4'd9});
        @(negedge clk);
        drive_idle();
        @(negedge clk);
        check(d_oe === 1'b0, "R9 forced off", {35'b0, d_oe}, '0);
        out_en = 1'b1;
        #1;
        check(d_oe === 1'b1 && d_out === ref_mem[8'h31], "R9 enabled mid-cycle", d_out, ref_mem[8'h31]);
        @(negedge clk);

        // R12 reset drops a pending read.
        drive_op('{1'b0,1'b0,CSON,1'b1,1'b1,8'h30,8'h30,4'hF,36'h0,4'd12});
        @(negedge clk);
        rst_n = 1'b0;
        drive_idle();
        @(negedge clk);
        check(d_oe === 1'b0, "R12 reset mid-run", {35'b0, d_oe}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(d_oe === 1'b0, "R12 nothing pending", {35'b0, d_oe}, '0);

        finish_run();
    end
endmodule